// File: doc/BRIEF.md
# Event Status and Interrupt Router

This block collects single-cycle event pulses from up to 96 peripheral sources and holds each one in a sticky status bit. The status bits sit in three 32-bit status words. Three output interrupt lines summarise the pending events. Each line has its own full bank of three 32-bit enable words, one for each status word, so software can route any event to any combination of lines.

Software reads and writes the registers over a simple word-addressed bus. The bus has a read strobe, a write strobe and 32-bit data, and read data is returned one cycle after the strobe. Software clears an event by writing a one to that event's status bit. To handle a line, software uses that line's lowest-pending-event index, the most recent status, or both. It can then acknowledge the event and, if it wishes, disable it.

Top module: `evt_router`

## Requirements
- R1: After reset, every status and enable register reads zero, all three interrupt lines are low, every valid flag is low and every pending index is zero.
- R2: A one on `evt_in[n]` for one cycle sets status bit n at the next clock edge. The bit then stays set until software acknowledges it.
- R3: Writing a status word clears exactly the bits that are written as one. Bits written as zero keep their value.
- R4: If event n pulses in the same cycle as an acknowledge of bit n, bit n is set after that edge, so the event is not lost.
- R5: Each enable word can be written and read back unchanged.
- R6: Line g (`irq_out[g]`) is registered. It is high one cycle after (status AND enable bank g) becomes non-zero, and it stays high for as long as that term stays non-zero.
- R7: An event whose enable bit is clear in bank g never raises line g. Clearing the last enable bit of a pending event drops the line one cycle after the write.
- R8: Any event, in any status word, can be routed to any line. Line 0 responds to events 64 to 95 and line 2 responds to events 32 to 63 when they are enabled there.
- R9: For line g, `pend_vld[g]` is high when (status AND bank g) is non-zero. In the same cycle, `pend_idx[7g+6:7g]` gives the lowest set event number, where the number is 32 × word + bit. The index is zero when nothing is pending.
- R10: The address map uses byte offsets, and `bus_addr` carries the offset divided by 4. Status words are at 0x00, 0x04 and 0x08. Enable word w of bank g is at 0x10 × (g+1) + 4w.
- R11: A read of an unmapped word, for example byte offsets 0x0C, 0x1C or 0x40, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 96 | Event pulses, bit n = event n |
| bus_addr | input | 6 | Word address (byte offset / 4) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_out | output | 3 | Registered interrupt lines, one per enable bank |
| pend_idx | output | 21 | Lowest pending event number, 7 bits per line |
| pend_vld | output | 3 | Pending flag per line |

## Verification
An event arrival and a software acknowledge of the same status bit can fall into the same clock cycle. The bench provokes this by pulsing event 5 while it writes a one to bit 5 of the status word at 0x00, with that bit already set. It judges the result by reading the word back and expecting the bit to still be set. A plain acknowledge with no event present then has to clear the same bit. The bench also checks the one-cycle offset between the combinational pending flag and the registered line after both mask and status changes.

// File: rtl/evt_router.sv
module evt_router #(
  parameter int DW = 32,
  parameter int NW = 3,
  parameter int NL = 3,
  parameter int AW = 6,
  localparam int NEV = DW * NW,
  localparam int IW = $clog2(NEV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEV-1:0]    evt_in,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NL-1:0]     irq_out,
  output logic [NL*IW-1:0]  pend_idx,
  output logic [NL-1:0]     pend_vld
);

  logic [NEV-1:0]    status_q;
  logic [NEV-1:0]    mask_q [NL];
  logic [NEV-1:0]    clr;
  logic [NL*NEV-1:0] act;
  logic [DW-1:0]     rd_mux;

  wire [AW-3:0] region = bus_addr[AW-1:2];
  wire [1:0]    sub    = bus_addr[1:0];

  always_comb begin
    clr = '0;
    for (int w = 0; w < NW; w++)
      if (bus_wr && region == '0 && sub == 2'(w))
        clr[w*DW +: DW] = bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr) | evt_in;
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < NL; g++)
      for (int w = 0; w < NW; w++)
        if (!rst_n)
          mask_q[g][w*DW +: DW] <= '0;
        else if (bus_wr && region == (AW-2)'(g+1) && sub == 2'(w))
          mask_q[g][w*DW +: DW] <= bus_wdata;
  end

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NW; w++) begin
      if (region == '0 && sub == 2'(w)) rd_mux = status_q[w*DW +: DW];
      for (int g = 0; g < NL; g++)
        if (region == (AW-2)'(g+1) && sub == 2'(w)) rd_mux = mask_q[g][w*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  for (genvar g = 0; g < NL; g++) begin : g_line
    assign act[g*NEV +: NEV] = status_q & mask_q[g];

    always_comb begin
      pend_idx[g*IW +: IW] = '0;
      pend_vld[g] = 1'b0;
      for (int i = NEV-1; i >= 0; i--)
        if (act[g*NEV + i]) begin
          pend_idx[g*IW +: IW] = IW'(i);
          pend_vld[g] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) irq_out[g] <= 1'b0;
      else        irq_out[g] <= |act[g*NEV +: NEV];
    end
  end

endmodule

module evt_router_chk #(
  parameter int NEV = 96,
  parameter int NL = 3,
  parameter int IW = 7,
  parameter int AW = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NEV-1:0]    evt_in,
  input logic [AW-1:0]     bus_addr,
  input logic              bus_wr,
  input logic [NEV-1:0]    status_q,
  input logic [NL*NEV-1:0] act,
  input logic [NL-1:0]     irq_out,
  input logic [NL*IW-1:0]  pend_idx,
  input logic [NL-1:0]     pend_vld
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (irq_out == '0 && status_q == '0)); // R1

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr[AW-1:2] == '0) |=> ((status_q & $past(status_q)) == $past(status_q))); // R2

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_in) |=> ((status_q & $past(evt_in)) == $past(evt_in))); // R4

  for (genvar g = 0; g < NL; g++) begin : g_chk
    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (irq_out[g] == $past(pend_vld[g]))); // R6

    AST_IDX_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      pend_vld[g] |-> act[g*NEV + int'(pend_idx[g*IW +: IW])]); // R9

    AST_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_vld[g] |-> (pend_idx[g*IW +: IW] == '0 && act[g*NEV +: NEV] == '0)); // R9
  end

endmodule

bind evt_router evt_router_chk #(.NEV(NEV), .NL(NL), .IW(IW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .status_q(status_q), .act(act), .irq_out(irq_out), .pend_idx(pend_idx), .pend_vld(pend_vld)
);

// File: tb/evt_router_test.sv
`timescale 1ns/1ps
module evt_router_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [95:0] evt_in = '0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_out, pend_vld;
  logic [20:0] pend_idx;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 0;

  always #4 clk = ~clk;

  evt_router uut (.clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .pend_idx(pend_idx), .pend_vld(pend_vld));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk("read without expectation", 1, 0);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic rd(logic [7:0] off, logic [31:0] exp, string tag);
    bus_addr = off[7:2]; bus_rd = 1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wr(logic [7:0] off, logic [31:0] d);
    bus_addr = off[7:2]; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic pulse(int n);
    evt_in[n] = 1;
    @(negedge clk); evt_in = '0;
  endtask

  function automatic logic [31:0] idx(int g);
    return 32'(pend_idx[g*7 +: 7]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state, R10 map
    chk("R1 irq", 32'(irq_out), 0);
    chk("R1 vld", 32'(pend_vld), 0);
    chk("R1 idx", 32'(pend_idx), 0);
    for (int a = 0; a < 64; a += 4)
      if (a[3:2] != 2'd3) rd(8'(a), 0, "R1 R10 reset read");

    // R5 enable readback
    wr(8'h28, 32'hA5A5_0F0F);
    wr(8'h10, 32'h1234_5678);
    wr(8'h34, 32'hDEAD_BEEF);
    rd(8'h28, 32'hA5A5_0F0F, "R5 bank1 w2");
    rd(8'h10, 32'h1234_5678, "R5 bank0 w0");
    rd(8'h34, 32'hDEAD_BEEF, "R5 bank2 w1");
    rd(8'h24, 0, "R10 bank1 w1 untouched");
    wr(8'h28, 0); wr(8'h10, 0); wr(8'h34, 0);

    // R11 unmapped
    rd(8'h0C, 0, "R11 0x0C");
    rd(8'h1C, 0, "R11 0x1C");
    rd(8'h40, 0, "R11 0x40");

    // R2 sticky, R7 masked
    pulse(40);
    repeat (3) @(negedge clk);
    rd(8'h04, 32'h0000_0100, "R2 status w1");
    chk("R7 masked irq", 32'(irq_out), 0);
    chk("R7 masked vld", 32'(pend_vld), 0);

    // R6 R8: event 40 on line 2
    wr(8'h34, 32'h0000_0100);
    chk("R9 vld line2", 32'(pend_vld), 3'b100);
    chk("R9 idx line2", idx(2), 40);
    chk("R6 irq one cycle late", 32'(irq_out), 0);
    @(negedge clk);
    chk("R6 R8 irq line2", 32'(irq_out), 3'b100);

    // R8 event 70 on line 0, R9 lowest
    wr(8'h18, 32'h0000_0040);
    pulse(70);
    chk("R9 idx line0", idx(0), 70);
    @(negedge clk);
    chk("R8 irq line0", 32'(irq_out), 3'b101);
    wr(8'h30, 32'hFFFF_FFFF);
    pulse(3);
    chk("R9 lowest line2", idx(2), 3);
    pulse(1);
    chk("R9 lower still", idx(2), 1);

    // R3 write-one-to-clear
    wr(8'h04, 0);
    rd(8'h04, 32'h0000_0100, "R3 zero write keeps");
    wr(8'h00, 32'h0000_0002);
    rd(8'h00, 32'h0000_0008, "R3 clears only ones");
    chk("R9 next lowest", idx(2), 3);

    // R4 set wins
    pulse(5);
    evt_in[5] = 1; bus_addr = 6'h00; bus_wdata = 32'h0000_0020; bus_wr = 1;
    @(negedge clk); evt_in = '0; bus_wr = 0;
    rd(8'h00, 32'h0000_0028, "R4 set beats clear");
    wr(8'h00, 32'h0000_0028);
    rd(8'h00, 0, "R3 plain clear");

    // R7 disabling drops line
    chk("R6 line0 held", 32'(irq_out[0]), 1);
    wr(8'h18, 0);
    chk("R7 vld0 drop", 32'(pend_vld[0]), 0);
    chk("R7 irq0 still high", 32'(irq_out[0]), 1);
    @(negedge clk);
    chk("R7 irq0 dropped", 32'(irq_out[0]), 0);
    wr(8'h04, 32'h0000_0100);
    @(negedge clk);
    chk("R6 irq2 drops after ack", 32'(irq_out), 0);
    chk("R9 idle idx", 32'(pend_idx), 0);

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) chk("queue drained", 32'(exp_q.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule